// File: doc/BRIEF.md
# Beacon-Synchronised Power-Save Sequencer

This block sequences the connected-idle power save of a wireless network processor. While enabled, it keeps the processor in a low-power, state-retaining mode between beacons. It wakes into a listen-only mode in time for the next beacon. When the beacon arrives, it checks whether the access point holds traffic for the station. If nothing is waiting, the sequencer goes back to low power and rearms its sleep timer. If traffic is waiting, it raises an active mode: layer-3 for IP traffic, layer-2 for management traffic. It stays there until the traffic is reported finished.

The sleep time is the beacon interval (in timer ticks) multiplied by a listen multiplier. It is clamped to a configurable ceiling that stands for a 22-second maximum. A listen window with no beacon is closed by a timeout, and a missed-beacon pulse reports it. Radio control and frame parsing live outside the block. The block only sees one-cycle strobes for a received beacon and for the traffic indication carried with it.

Top module: `psave_seq`

## Requirements
- R1: While reset is applied and after it is released, `mode` reads disabled (code 0) and `wake_req`, `act_req` and `bcn_miss` are low until the sequencer acts.
- R2: A cycle with `enable` low makes `mode` disabled (0) on the next cycle from any mode. A cycle with `enable` high in disabled moves to low power (code 1) on the next cycle.
- R3: Low power lasts exactly S cycles, where S = `bcn_period` × `listen_mult`, or 1 when that product is zero. Listen (code 2) follows, and `wake_req` is high during the first listen cycle only.
- R4: S never exceeds the parameter `MAX_SLEEP`; a larger product sleeps exactly `MAX_SLEEP` cycles.
- R5: `bcn_rx` in listen with `traffic_pend` low returns to low power on the next cycle, with a freshly loaded sleep time.
- R6: `bcn_rx` in listen with `traffic_pend` high enters layer-3 active (code 4) when `traffic_ip` is high, else layer-2 active (code 3). `act_req` is high during the first active cycle only.
- R7: If no `bcn_rx` arrives during `LISTEN_TO` listen cycles, the sequencer returns to low power, and `bcn_miss` is high during the first low-power cycle only.
- R8: `bcn_rx`, `traffic_pend` and `traffic_ip` have no effect outside listen mode.
- R9: `traffic_done` in either active mode returns to low power with a fresh sleep time. In any other mode it has no effect.
- R10: A beacon that arrives in the last cycle of the listen window is accepted, and no miss is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Connected-idle power save enabled |
| bcn_period | input | BI_W | Beacon interval in timer cycles |
| listen_mult | input | LM_W | Number of beacon intervals slept per cycle |
| bcn_rx | input | 1 | Strobe: a beacon was received |
| traffic_pend | input | 1 | With `bcn_rx`: traffic is buffered for this station |
| traffic_ip | input | 1 | With `bcn_rx`: pending traffic needs IP processing |
| traffic_done | input | 1 | Strobe: the active exchange has finished |
| mode | output | 3 | Current mode: 0 disabled, 1 low power, 2 listen, 3 layer-2 active, 4 layer-3 active |
| wake_req | output | 1 | Pulse in the first listen cycle |
| act_req | output | 1 | Pulse in the first active cycle |
| bcn_miss | output | 1 | Pulse in the first low-power cycle after a listen timeout |

## Verification
The hardest case to reach from the ports is a beacon that lands in the very last cycle of the listen window, where acceptance and timeout would coincide. The bench follows its own model's remaining-cycle count and waits until the model reports one listen cycle left. It then fires `bcn_rx`. The clamp case is the other awkward one, because its sleep time depends on a product above `MAX_SLEEP`. It is reached by driving a large interval and multiplier, on top of long random runs that also toggle `enable` in every mode.

// File: rtl/psave_pkg.sv
package psave_pkg;
  typedef enum logic [2:0] {
    MODE_OFF    = 3'd0,
    MODE_SLEEP  = 3'd1,
    MODE_LISTEN = 3'd2,
    MODE_MGMT   = 3'd3,
    MODE_IP     = 3'd4
  } psave_mode_e;
endpackage

// File: rtl/psave_rst_sync.sv
module psave_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q = sync_q[1];
endmodule

// File: rtl/psave_sleep_calc.sv
module psave_sleep_calc #(
  parameter int BI_W      = 20,
  parameter int LM_W      = 5,
  parameter int CNT_W     = 25,
  parameter int MAX_SLEEP = 22_000_000
) (
  input  logic [BI_W-1:0]  period,
  input  logic [LM_W-1:0]  mult,
  output logic [CNT_W-1:0] sleep_len
);
  localparam int PW = BI_W + LM_W;
  localparam int EW = (PW > CNT_W) ? PW + 1 : CNT_W + 1;
  localparam logic [EW-1:0] CEIL = EW'(MAX_SLEEP);

  logic [PW-1:0] prod;
  logic [EW-1:0] prod_e;
  logic [EW-1:0] clamped;

  always_comb begin
    prod   = PW'(period) * PW'(mult);
    prod_e = EW'(prod);
    if (prod_e == '0)       clamped = EW'(1);
    else if (prod_e > CEIL) clamped = CEIL;
    else                    clamped = prod_e;
    sleep_len = CNT_W'(clamped);
  end
endmodule

// File: rtl/psave_timer.sv
module psave_timer #(
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst_q,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CNT_W'(1));

  // R3: an idle counter stays at zero rather than wrapping
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (cnt_q == '0 && !load) |=> cnt_q == '0);
endmodule

// File: rtl/psave_seq.sv
module psave_seq
  import psave_pkg::*;
#(
  parameter int BI_W      = 20,
  parameter int LM_W      = 5,
  parameter int MAX_SLEEP = 22_000_000,
  parameter int LISTEN_TO = 20_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [BI_W-1:0] bcn_period,
  input  logic [LM_W-1:0] listen_mult,
  input  logic            bcn_rx,
  input  logic            traffic_pend,
  input  logic            traffic_ip,
  input  logic            traffic_done,
  output logic [2:0]      mode,
  output logic            wake_req,
  output logic            act_req,
  output logic            bcn_miss
);
  localparam int TOP   = (MAX_SLEEP > LISTEN_TO) ? MAX_SLEEP : LISTEN_TO;
  localparam int CNT_W = $clog2(TOP + 1);

  logic             rst_q;
  logic [CNT_W-1:0] sleep_len;
  logic [CNT_W-1:0] load_val;
  logic             tmr_load, tmr_last;
  psave_mode_e      cur_q, nxt;
  logic             wake_d, act_d, miss_d;
  logic             wake_q, act_q, miss_q;

  psave_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  psave_sleep_calc #(
    .BI_W(BI_W), .LM_W(LM_W), .CNT_W(CNT_W), .MAX_SLEEP(MAX_SLEEP)
  ) i_calc (
    .period(bcn_period), .mult(listen_mult), .sleep_len(sleep_len)
  );

  psave_timer #(.CNT_W(CNT_W)) i_tmr (
    .clk(clk), .rst_q(rst_q), .load(tmr_load), .load_val(load_val), .last(tmr_last)
  );

  // next-state logic
  always_comb begin
    nxt    = cur_q;
    wake_d = 1'b0;
    act_d  = 1'b0;
    miss_d = 1'b0;
    if (!enable) begin
      nxt = MODE_OFF;
    end else begin
      unique case (cur_q)
        MODE_OFF:   nxt = MODE_SLEEP;
        MODE_SLEEP: if (tmr_last) begin
          nxt    = MODE_LISTEN;
          wake_d = 1'b1;
        end
        MODE_LISTEN: if (bcn_rx) begin
          if (traffic_pend) begin
            nxt   = traffic_ip ? MODE_IP : MODE_MGMT;
            act_d = 1'b1;
          end else begin
            nxt = MODE_SLEEP;
          end
        end else if (tmr_last) begin
          nxt    = MODE_SLEEP;
          miss_d = 1'b1;
        end
        MODE_MGMT, MODE_IP: if (traffic_done) nxt = MODE_SLEEP;
        default: nxt = MODE_OFF;
      endcase
    end
  end

  assign tmr_load = (nxt != cur_q) && (nxt == MODE_SLEEP || nxt == MODE_LISTEN);
  assign load_val = (nxt == MODE_LISTEN) ? CNT_W'(LISTEN_TO) : sleep_len;

  // state registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cur_q  <= MODE_OFF;
      wake_q <= 1'b0;
      act_q  <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      cur_q  <= nxt;
      wake_q <= wake_d;
      act_q  <= act_d;
      miss_q <= miss_d;
    end
  end

  assign mode     = cur_q;
  assign wake_req = wake_q;
  assign act_req  = act_q;
  assign bcn_miss = miss_q;

  p_off_when_disabled_r2: assert property (@(posedge clk) disable iff (!rst_q)
    !enable |=> mode == MODE_OFF);

  p_wake_from_sleep_r3: assert property (@(posedge clk) disable iff (!rst_q)
    wake_req |-> (mode == MODE_LISTEN && $past(mode) == MODE_SLEEP));

  p_clamp_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (sleep_len != '0) && (sleep_len <= CNT_W'(MAX_SLEEP)));

  p_act_from_listen_r6: assert property (@(posedge clk) disable iff (!rst_q)
    act_req |-> ((mode == MODE_MGMT || mode == MODE_IP) && $past(mode) == MODE_LISTEN));

  p_miss_after_listen_r7: assert property (@(posedge clk) disable iff (!rst_q)
    bcn_miss |-> (mode == MODE_SLEEP && $past(mode) == MODE_LISTEN));

  p_sleep_ignores_bcn_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (mode == MODE_SLEEP && enable && !tmr_last) |=> mode == MODE_SLEEP);
endmodule

// File: tb/test_psave_seq.sv
module test_psave_seq;
  localparam int BI_W = 8, LM_W = 3, MAXS = 60, LTO = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, bcn_rx = 1'b0, traffic_pend = 1'b0, traffic_ip = 1'b0, traffic_done = 1'b0;
  logic [BI_W-1:0] bcn_period = '0;
  logic [LM_W-1:0] listen_mult = '0;
  logic [2:0] mode;
  logic wake_req, act_req, bcn_miss;

  int checks = 0, errors = 0;
  int em = 0, rem = 0;
  bit ew = 0, ea = 0, ems = 0;
  string etag = "R1";
  bit finished = 0;

  always #5 clk = ~clk;

  psave_seq #(.BI_W(BI_W), .LM_W(LM_W), .MAX_SLEEP(MAXS), .LISTEN_TO(LTO)) i_psave_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bcn_period(bcn_period),
    .listen_mult(listen_mult), .bcn_rx(bcn_rx), .traffic_pend(traffic_pend),
    .traffic_ip(traffic_ip), .traffic_done(traffic_done), .mode(mode),
    .wake_req(wake_req), .act_req(act_req), .bcn_miss(bcn_miss));

  function automatic int slen(int p, int m);
    int s = p * m;
    if (s == 0) return 1;
    if (s > MAXS) return MAXS;
    return s;
  endfunction

  task automatic compare();
    checks++;
    if (mode !== 3'(em) || wake_req !== ew || act_req !== ea || bcn_miss !== ems) begin
      errors++;
      $display("FAIL %s: mode/wake/act/miss = %0d/%b/%b/%b expected %0d/%b/%b/%b",
               etag, mode, wake_req, act_req, bcn_miss, em, ew, ea, ems);
    end
  endtask

  // Apply one cycle of inputs, advance the reference, check after the edge.
  task automatic step(bit en, bit b, bit p, bit ip, bit d);
    int s;
    enable = en; bcn_rx = b; traffic_pend = p; traffic_ip = ip; traffic_done = d;
    s = slen(int'(bcn_period), int'(listen_mult));
    ew = 0; ea = 0; ems = 0;
    if (!en) begin
      em = 0; etag = "R2";
    end else begin
      case (em)
        0: begin em = 1; rem = s; etag = "R2"; end
        1: begin
          etag = (b || p || d) ? "R8" : "R3";
          if (rem == 1) begin em = 2; rem = LTO; ew = 1; end
          else rem--;
        end
        2: begin
          if (b) begin
            etag = (rem == 1) ? "R10" : (p ? "R6" : "R5");
            if (p) begin em = ip ? 4 : 3; ea = 1; end
            else begin em = 1; rem = s; end
          end else begin
            etag = "R7";
            if (rem == 1) begin em = 1; rem = s; ems = 1; end
            else rem--;
          end
        end
        default: begin
          etag = (b || p) ? "R8" : "R9";
          if (d) begin em = 1; rem = s; end
        end
      endcase
    end
    @(negedge clk);
    compare();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    etag = "R1"; compare();
    rst_n = 1'b1;
    repeat (4) step(0, 0, 0, 0, 0);
    etag = "R1"; compare();

    // R3: interval 5 x 3 = 15 cycles of sleep, beacons in sleep ignored (R8)
    bcn_period = 8'd5; listen_mult = 3'd3;
    step(1, 0, 0, 0, 0);
    repeat (15) step(1, 1, 1, 1, 0);
    // R10: beacon on the last listen cycle
    while (rem != 1) step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    if (em != 1) begin errors++; $display("FAIL R10: model state %0d expected 1", em); end
    // R4: clamp 200 x 7 > MAXS
    bcn_period = 8'd200; listen_mult = 3'd7;
    while (em != 2) step(1, 0, 0, 0, 1);
    // R7: timeout with no beacon
    repeat (LTO) step(1, 0, 0, 0, 0);
    // zero product sleeps one cycle (R3)
    bcn_period = 8'd0;
    while (em != 2) step(1, 0, 0, 0, 0);
    // R6: layer-3 then R9 done, then layer-2
    step(1, 1, 1, 1, 0);
    repeat (3) step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 1);
    while (em != 2) step(1, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0);
    step(1, 0, 0, 0, 1);

    // constrained random
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 99) == 0) begin
        bcn_period = 8'($urandom_range(0, 40));
        listen_mult = 3'($urandom_range(0, 7));
      end
      step($urandom_range(0, 299) != 0, $urandom_range(0, 5) == 0,
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
           $urandom_range(0, 7) == 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule